// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block computes odd parity over a nine-bit data word and shares a single parity line with a bus. An active-low transmit control selects the mode. With transmit asserted the block drives the generated parity bit onto the line, so the nine data bits and the parity bit together always hold an odd number of ones. With transmit released the block lets go of the line, reads the bit another agent places there, and pulls an active-low error flag when the ten bits hold an even number of ones.

The bidirectional line is split into a parity input, a parity output and an output enable. An active-high reset stands in for power ramping: while it is held the enable stays low, so the line floats, and the error flag stays inactive. The datapath has no clock. Words wider than nine bits are covered by chaining units, with one unit's generated bit feeding a data input of the next.

Top module: `bus_parity_unit`

## Requirements
- R1: The generated bit on `par_out` is 1 when an even number (0, 2, 4, 6 or 8) of the nine `data` bits are 1, and 0 when that number is odd.
- R2: With `rst` low and `xmit_n` low, `par_oe` is 1.
- R3: With `xmit_n` high, `par_oe` is 0.
- R4: With `xmit_n` low, `err_n` is 1 for every data pattern and every `par_in` value.
- R5: With `rst` low and `xmit_n` high, `err_n` is 0 when `data` has an even count of ones and `par_in` is 0.
- R6: With `rst` low and `xmit_n` high, `err_n` is 0 when `data` has an odd count of ones and `par_in` is 1; for the other two combinations `err_n` is 1.
- R7: While `rst` is 1, `par_oe` is 0 and `err_n` is 1, whatever the other inputs are.
- R8: Once `rst` falls, the outputs follow R2 to R6 at once, with no clock edge needed.
- R9: `par_out` carries the generated bit in both modes, so it never goes unknown while the enable is low.
- R10: When the `par_out` of a transmitting unit feeds `data[0]` of a second transmitting unit whose `data[8:1]` carry eight further bits, the second unit's `par_out` is 1 exactly when the seventeen data bits hold an odd count of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high power-ramp reset; floats the parity line |
| xmit_n | input | 1 | Transmit control, active low |
| data | input | 9 | Data word covered by the parity |
| par_in | input | 1 | Value seen on the shared parity line |
| par_out | output | 1 | Generated parity bit, driven when enabled |
| par_oe | output | 1 | Output enable for the parity line |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The assertions sit in combinational blocks and take for granted that every input is a settled known value whenever they evaluate; they skip any evaluation while an input is unknown. The bench meets this by setting every input in its first statement and changing inputs only in the half of the clock away from the sampling point, so each check sees a fully settled state. All 512 data words are swept against both modes, both line values and both reset levels, and the chained pair is swept over 512 words with varied upper bits.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
  localparam int DATA_W = 9;

  // 1 when the word holds an odd number of ones
  function automatic logic odd_ones(input logic [DATA_W-1:0] w);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) acc = acc ^ w[i];
    return acc;
  endfunction

  // generated bit: makes word plus bit hold an odd count
  function automatic logic gen_bit(input logic word_odd);
    return ~word_odd;
  endfunction

  // checker: flag is low when word plus line bit hold an even count
  function automatic logic flag_n(input logic word_odd, input logic line_bit);
    return word_odd ^ line_bit;
  endfunction
endpackage

// File: rtl/parity_chain.sv
module parity_chain #(
  parameter int W = bus_parity_pkg::DATA_W
) (
  input  logic [W-1:0] word,
  output logic         word_odd
);
  logic [W:0] stage;

  assign stage[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_stage
    assign stage[g+1] = stage[g] ^ word[g];
  end
  assign word_odd = stage[W];

  always_comb begin
    if (!$isunknown(word)) begin
      a_r1_chain_matches: assert (word_odd == bus_parity_pkg::odd_ones(word));
    end
  end
endmodule

// File: rtl/line_driver.sv
module line_driver (
  input  logic rst,
  input  logic xmit_n,
  input  logic word_odd,
  output logic line_out,
  output logic line_oe
);
  logic tx_active;

  assign tx_active = ~rst & ~xmit_n;
  assign line_out  = bus_parity_pkg::gen_bit(word_odd);
  assign line_oe   = tx_active;

  always_comb begin
    if (!$isunknown({rst, xmit_n, word_odd})) begin
      if (rst) a_r7_line_floats: assert (!line_oe);
      if (xmit_n) a_r3_rx_released: assert (!line_oe);
      if (!rst && !xmit_n) a_r2_tx_driven: assert (line_oe);
      a_r9_out_known: assert (!$isunknown(line_out));
    end
  end
endmodule

// File: rtl/mismatch_check.sv
module mismatch_check (
  input  logic rst,
  input  logic xmit_n,
  input  logic word_odd,
  input  logic line_in,
  output logic err_n
);
  logic rx_active;
  logic raw_flag_n;

  assign rx_active  = ~rst & xmit_n;
  assign raw_flag_n = bus_parity_pkg::flag_n(word_odd, line_in);
  assign err_n      = rx_active ? raw_flag_n : 1'b1;

  always_comb begin
    if (!$isunknown({rst, xmit_n, word_odd, line_in})) begin
      if (!xmit_n) a_r4_tx_no_error: assert (err_n);
      if (rst) a_r7_flag_idle: assert (err_n);
      if (rx_active && !word_odd && !line_in) a_r5_even_zero: assert (!err_n);
      if (rx_active && word_odd && line_in) a_r6_odd_one: assert (!err_n);
    end
  end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int DATA_W = bus_parity_pkg::DATA_W
) (
  input  logic              rst,
  input  logic              xmit_n,
  input  logic [DATA_W-1:0] data,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              err_n
);
  logic word_odd;

  parity_chain #(.W(DATA_W)) u_chain (
    .word     (data),
    .word_odd (word_odd)
  );

  line_driver u_drv (
    .rst      (rst),
    .xmit_n   (xmit_n),
    .word_odd (word_odd),
    .line_out (par_out),
    .line_oe  (par_oe)
  );

  mismatch_check u_chk (
    .rst      (rst),
    .xmit_n   (xmit_n),
    .word_odd (word_odd),
    .line_in  (par_in),
    .err_n    (err_n)
  );

  always_comb begin
    if (!$isunknown({rst, xmit_n, data, par_in})) begin
      if (par_oe) a_r4_driving_no_flag: assert (err_n);
      if (!err_n) a_r3_flag_only_released: assert (!par_oe);
    end
  end
endmodule

// File: tb/test_bus_parity_unit.sv
module test_bus_parity_unit;
  logic       clk = 1'b0;
  logic       rst, xmit_n, par_in;
  logic [8:0] data;
  logic       par_out, par_oe, err_n;
  logic [7:0] hi_bits;
  logic       c_out, c_oe, c_err;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bus_parity_unit i_bus_parity_unit (
    .rst(rst), .xmit_n(xmit_n), .data(data), .par_in(par_in),
    .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
  );

  // second unit chained on the first unit's generated bit (R10)
  bus_parity_unit u_next (
    .rst(rst), .xmit_n(1'b0), .data({hi_bits, par_out}), .par_in(1'b0),
    .par_out(c_out), .par_oe(c_oe), .err_n(c_err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s data=%h xmit_n=%b par_in=%b rst=%b actual=%b expected=%b",
               tag, data, xmit_n, par_in, rst, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xmit_n = 1'b0; par_in = 1'b0; data = '0; hi_bits = '0;
    @(negedge clk); @(posedge clk); #1;
    chk("R7 reset oe", par_oe, 1'b0);
    chk("R7 reset err", err_n, 1'b1);

    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 512; d++) begin
            @(negedge clk);
            rst = r[0]; xmit_n = m[0]; par_in = p[0]; data = d[8:0];
            @(posedge clk); #1;
            begin
              bit even_cnt;
              even_cnt = ($countones(d[8:0]) % 2) == 0;
              chk("R1 R9 generated bit", par_out, even_cnt);
              if (r == 1) begin
                chk("R7 oe held low", par_oe, 1'b0);
                chk("R7 err held high", err_n, 1'b1);
              end else if (m == 0) begin
                chk("R2 oe in transmit", par_oe, 1'b1);
                chk("R4 err in transmit", err_n, 1'b1);
              end else begin
                chk("R3 oe in receive", par_oe, 1'b0);
                if (even_cnt && p == 0) chk("R5 even data, line 0", err_n, 1'b0);
                else if (!even_cnt && p == 1) chk("R6 odd data, line 1", err_n, 1'b0);
                else chk("R6 consistent parity", err_n, 1'b1);
              end
            end
          end

    // R8: release reset without waiting for a clock edge
    @(negedge clk);
    rst = 1'b1; xmit_n = 1'b1; par_in = 1'b0; data = 9'h000;
    #1 rst = 1'b0;
    #0.5;
    chk("R8 err after release", err_n, 1'b0);
    xmit_n = 1'b0;
    #0.5;
    chk("R8 oe after release", par_oe, 1'b1);

    // R10: chained pair over seventeen bits
    rst = 1'b0; xmit_n = 1'b0;
    for (int d = 0; d < 512; d++) begin
      @(negedge clk);
      data = d[8:0];
      hi_bits = 8'(d * 37 + 11);
      @(posedge clk); #1;
      chk("R10 chained parity", c_out,
          logic'(($countones(d[8:0]) + $countones(hi_bits)) % 2));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule